// File: doc/BRIEF.md
# Key Change Interrupt Unit

This unit watches a 64-bit vector of debounced key states from an 8x8 key matrix and turns transitions of each key into latched events. Every key has its own 2-bit edge selector that picks which transitions count: none, press (0 to 1), release (1 to 0), or both. A detected transition sets that key's bit in a status vector. The bit stays set until software writes a one to the matching bit of a clear word. The status bits are gated by a per-key enable mask and OR-reduced into one interrupt line.

Software reaches the unit through a simple word-wide register port with a write strobe and a combinational read path. The 64-bit vectors are split into a low word and a high word. The low word holds rows 0 to 3 and the high word holds rows 4 to 7. Two further plain storage words are carried through to the neighbouring scan logic: a control word and a pin-direction word.

Top module: `key_event_irq`

## Requirements
- R1: After reset, every readable register reads zero, the interrupt is low, and both carried-through words are zero.
- R2: Key k = row*8 + col has a 2-bit edge code in the edge-mode word at 0x90 + 4*(k/16), bits [2*(k%16)+1 : 2*(k%16)]. Code 0 gives no events. Code 1 gives events on 0-to-1 only. Code 2 gives events on 1-to-0 only. Code 3 gives events on both. The edge-mode words are read/write.
- R3: A selected transition of key k sets status bit k. That bit is read at 0xC0 (rows 0-3) or 0xC4 (rows 4-7), at bit (row mod 4)*8 + col. The bit becomes visible one clock edge after the input changes and holds until cleared.
- R4: The key-state words read the key vector as sampled at the last clock edge, at 0xA0 (rows 0-3) and 0xA4 (rows 4-7), with the same bit layout as the status words.
- R5: Writing a word to 0xB8 (low) or 0xBC (high) clears exactly the status bits where the written data holds a one. The other status bits are unchanged. The clear words read as zero.
- R6: If a new event and a clear hit the same status bit at the same clock edge, the bit ends up set.
- R7: The mask words at 0xB0 and 0xB4 are read/write and use the status layout, where 1 enables the key. The interrupt is high exactly when some status bit and its mask bit are both one. Status bits latch regardless of the mask.
- R8: The control word at 0x80 and the direction word at 0x84 are read/write and are driven unchanged on their output ports.
- R9: Reads of unmapped offsets return zero. Writes to the state words, the status words or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyState | input | 64 | Debounced key levels, bit row*8+col |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Write strobe for the addressed word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| irqOut | output | 1 | Masked OR of all status bits |
| ctrlWord | output | 32 | Stored control word |
| dirWord | output | 32 | Stored pin-direction word |

## Verification
A register write takes effect at the clock edge where the strobe is high, so its result is read back after that edge. A change on keyState lands in status, in the state words and in the interrupt one edge later. Reads are combinational from the address and settle in the same cycle. The bench drives every input on the falling edge and samples on the next falling edge, which is exactly one active edge after the stimulus. It sweeps all 64 keys through all four edge codes in both directions, and the expected words are computed from the key index.

// File: rtl/key_event_irq_pkg.sv
package key_event_irq_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 8;
  localparam int NUM_KEYS   = 64;
  localparam int MODE_W     = 2;
  localparam int ADDR_STEP  = REG_W / 8;
  localparam int KEYS_PER_MODE_WORD = REG_W / MODE_W;
  localparam int NUM_MODE_WORDS = NUM_KEYS / KEYS_PER_MODE_WORD;
  localparam int NUM_HALF   = NUM_KEYS / REG_W;
  localparam int IDX_W      = $clog2(NUM_MODE_WORDS);
  localparam int HALF_W     = (NUM_HALF > 1) ? $clog2(NUM_HALF) : 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'h80;
  localparam logic [ADDR_W-1:0] ADDR_DIR    = 8'h84;
  localparam logic [ADDR_W-1:0] ADDR_MODE0  = 8'h90;
  localparam logic [ADDR_W-1:0] ADDR_STATE0 = 8'hA0;
  localparam logic [ADDR_W-1:0] ADDR_MASK0  = 8'hB0;
  localparam logic [ADDR_W-1:0] ADDR_CLR0   = 8'hB8;
  localparam logic [ADDR_W-1:0] ADDR_STAT0  = 8'hC0;

  typedef struct packed {
    logic [NUM_MODE_WORDS-1:0] wrMode;
    logic [NUM_HALF-1:0]       wrMask;
    logic [NUM_HALF-1:0]       wrClr;
    logic                      wrCtrl;
    logic                      wrDir;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_DIR, SEL_MODE, SEL_STATE, SEL_MASK, SEL_STATUS
  } rdSel_t;
endpackage

// File: rtl/key_event_irq_ctrl.sv
module key_event_irq_ctrl
  import key_event_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobes_t      strobes,
  output rdSel_t            rdSel,
  output logic [IDX_W-1:0]  rdIdx
);

  always_comb begin
    strobes = '0;
    rdSel   = SEL_NONE;
    rdIdx   = '0;
    if (regAddr == ADDR_CTRL) begin
      rdSel = SEL_CTRL;
      strobes.wrCtrl = regWrEn;
    end
    if (regAddr == ADDR_DIR) begin
      rdSel = SEL_DIR;
      strobes.wrDir = regWrEn;
    end
    for (int i = 0; i < NUM_MODE_WORDS; i++) begin
      if (regAddr == ADDR_MODE0 + ADDR_W'(ADDR_STEP * i)) begin
        rdSel = SEL_MODE;
        rdIdx = IDX_W'(i);
        strobes.wrMode[i] = regWrEn;
      end
    end
    for (int i = 0; i < NUM_HALF; i++) begin
      if (regAddr == ADDR_STATE0 + ADDR_W'(ADDR_STEP * i)) begin
        rdSel = SEL_STATE;
        rdIdx = IDX_W'(i);
      end
      if (regAddr == ADDR_MASK0 + ADDR_W'(ADDR_STEP * i)) begin
        rdSel = SEL_MASK;
        rdIdx = IDX_W'(i);
        strobes.wrMask[i] = regWrEn;
      end
      if (regAddr == ADDR_CLR0 + ADDR_W'(ADDR_STEP * i)) begin
        strobes.wrClr[i] = regWrEn;
      end
      if (regAddr == ADDR_STAT0 + ADDR_W'(ADDR_STEP * i)) begin
        rdSel = SEL_STATUS;
        rdIdx = IDX_W'(i);
      end
    end
  end

  // R9: a write never reaches more than one storage word
  always_comb begin
    p_single_target_r9: assert ($onehot0(strobes));
  end

endmodule

// File: rtl/key_event_irq_dp.sv
module key_event_irq_dp
  import key_event_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] keyState,
  input  ctrlStrobes_t        strobes,
  input  rdSel_t              rdSel,
  input  logic [IDX_W-1:0]    rdIdx,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  output logic                irqOut,
  output logic [REG_W-1:0]    ctrlWord,
  output logic [REG_W-1:0]    dirWord
);

  logic [NUM_KEYS-1:0] keyPrev;
  logic [NUM_KEYS-1:0] statusReg;
  logic [NUM_KEYS-1:0] evVec;
  logic [NUM_KEYS-1:0] clrVec;
  logic [NUM_MODE_WORDS-1:0][REG_W-1:0] modeReg;
  logic [NUM_HALF-1:0][REG_W-1:0] maskWords;
  logic [NUM_HALF-1:0][REG_W-1:0] stateWords;
  logic [NUM_HALF-1:0][REG_W-1:0] statusWords;
  logic [NUM_KEYS-1:0] maskFlat;
  logic [REG_W-1:0] ctrlReg;
  logic [REG_W-1:0] dirReg;

  assign stateWords  = keyPrev;
  assign statusWords = statusReg;
  assign maskFlat    = maskWords;

  // per-key edge detection from the key's 2-bit code
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    logic [MODE_W-1:0] fld;
    assign fld = modeReg[k / KEYS_PER_MODE_WORD][MODE_W * (k % KEYS_PER_MODE_WORD) +: MODE_W];
    assign evVec[k] = (fld[0] & keyState[k] & ~keyPrev[k])
                    | (fld[1] & ~keyState[k] & keyPrev[k]);
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_clr
    assign clrVec[h*REG_W +: REG_W] = strobes.wrClr[h] ? wrData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyPrev   <= '0;
      statusReg <= '0;
      modeReg   <= '0;
      maskWords <= '0;
      ctrlReg   <= '0;
      dirReg    <= '0;
    end else begin
      keyPrev   <= keyState;
      statusReg <= (statusReg & ~clrVec) | evVec;
      for (int i = 0; i < NUM_MODE_WORDS; i++)
        if (strobes.wrMode[i]) modeReg[i] <= wrData;
      for (int i = 0; i < NUM_HALF; i++)
        if (strobes.wrMask[i]) maskWords[i] <= wrData;
      if (strobes.wrCtrl) ctrlReg <= wrData;
      if (strobes.wrDir)  dirReg  <= wrData;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_CTRL:   rdData = ctrlReg;
      SEL_DIR:    rdData = dirReg;
      SEL_MODE:   rdData = modeReg[rdIdx];
      SEL_STATE:  rdData = stateWords[rdIdx[HALF_W-1:0]];
      SEL_MASK:   rdData = maskWords[rdIdx[HALF_W-1:0]];
      SEL_STATUS: rdData = statusWords[rdIdx[HALF_W-1:0]];
      default:    rdData = '0;
    endcase
  end

  assign irqOut   = |(statusReg & maskFlat);
  assign ctrlWord = ctrlReg;
  assign dirWord  = dirReg;

  // R3 and R6: every detected event is present in status after the edge
  p_event_latched_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|evVec) |=> ((statusReg & $past(evVec)) == $past(evVec)));

  // R5: cleared bits without a competing event are gone after the edge
  p_clear_effect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|clrVec) |=> ((statusReg & $past(clrVec & ~evVec)) == '0));

  // R3: status holds when there is neither an event nor a clear
  p_status_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!(|evVec) && !(|clrVec)) |=> $stable(statusReg));

  // R7: no enabled key means no interrupt
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (maskFlat == '0) |-> !irqOut);

endmodule

// File: rtl/key_event_irq.sv
module key_event_irq
  import key_event_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] keyState,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic                irqOut,
  output logic [REG_W-1:0]    ctrlWord,
  output logic [REG_W-1:0]    dirWord
);

  ctrlStrobes_t     strobes;
  rdSel_t           rdSel;
  logic [IDX_W-1:0] rdIdx;

  key_event_irq_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes),
    .rdSel   (rdSel),
    .rdIdx   (rdIdx)
  );

  key_event_irq_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .keyState (keyState),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .rdIdx    (rdIdx),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .ctrlWord (ctrlWord),
    .dirWord  (dirWord)
  );

endmodule

// File: tb/key_event_irq_tb_top.sv
module key_event_irq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] keyState = '0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  logic [31:0] ctrlWord;
  logic [31:0] dirWord;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  key_event_irq dut_i (
    .clk(clk), .rstN(rstN), .keyState(keyState), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .ctrlWord(ctrlWord), .dirWord(dirWord)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = 8'h00;
  endtask

  task automatic clearAll();
    wr(8'hB8, 32'hFFFF_FFFF);
    wr(8'hBC, 32'hFFFF_FFFF);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] pat;
    logic [63:0] pat2;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    foreach (v[i]) begin end
    for (int a = 8'h80; a <= 8'hC4; a += 4) begin
      rd(8'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 irq", {31'h0, irqOut}, 32'h0);
    check("R1 ctrl out", ctrlWord, 32'h0);
    check("R1 dir out", dirWord, 32'h0);

    // R8: carried-through words
    wr(8'h80, 32'hDEAD_0123);
    wr(8'h84, 32'h00FF_5A00);
    rd(8'h80, v); check("R8 ctrl read", v, 32'hDEAD_0123);
    rd(8'h84, v); check("R8 dir read", v, 32'h00FF_5A00);
    check("R8 ctrl out", ctrlWord, 32'hDEAD_0123);
    check("R8 dir out", dirWord, 32'h00FF_5A00);

    // R7: mask read/write
    wr(8'hB0, 32'hFFFF_FFFF);
    wr(8'hB4, 32'hFFFF_FFFF);
    rd(8'hB4, v); check("R7 mask read", v, 32'hFFFF_FFFF);

    // R2, R3, R4: sweep each key through all four codes, both directions
    for (int k = 0; k < 64; k++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] bitw;
        bitw = 32'h1 << (k % 32);
        for (int w = 0; w < 4; w++)
          wr(8'(8'h90 + 4*w), (w == k/16) ? (32'(m) << (2*(k%16))) : 32'h0);
        rd(8'(8'h90 + 4*(k/16)), v);
        check("R2 mode read", v, 32'(m) << (2*(k%16)));
        clearAll();
        keyState[k] = 1'b1;
        @(negedge clk);
        rd(8'(8'hC0 + 4*(k/32)), v);
        check("R2 R3 rise status", v, m[0] ? bitw : 32'h0);
        rd(8'(8'hC0 + 4*(1 - k/32)), v);
        check("R3 other status word", v, 32'h0);
        check("R7 irq rise", {31'h0, irqOut}, {31'h0, m[0]});
        rd(8'(8'hA0 + 4*(k/32)), v);
        check("R4 state word", v, bitw);
        clearAll();
        keyState[k] = 1'b0;
        @(negedge clk);
        rd(8'(8'hC0 + 4*(k/32)), v);
        check("R2 R3 fall status", v, m[1] ? bitw : 32'h0);
        clearAll();
      end
    end

    // R3 and R4: multi-key patterns with all codes set to both
    for (int w = 0; w < 4; w++) wr(8'(8'h90 + 4*w), 32'hFFFF_FFFF);
    clearAll();
    pat = 64'hA5A5_0F0F_1234_8001;
    keyState = pat;
    @(negedge clk);
    rd(8'hC0, v); check("R3 pattern low", v, pat[31:0]);
    rd(8'hC4, v); check("R3 pattern high", v, pat[63:32]);
    rd(8'hA4, v); check("R4 pattern state high", v, pat[63:32]);
    clearAll();
    pat2 = 64'h0FF0_3C3C_FFFF_0000;
    keyState = pat2;
    @(negedge clk);
    rd(8'hC0, v); check("R3 toggled low", v, pat[31:0] ^ pat2[31:0]);
    rd(8'hC4, v); check("R3 toggled high", v, pat[63:32] ^ pat2[63:32]);

    // R5: partial clear, clear words read zero
    clearAll();
    keyState = '0;
    @(negedge clk);
    wr(8'hBC, 32'h0000_0300);
    rd(8'hC0, v); check("R5 keep low", v, pat2[31:0]);
    rd(8'hC4, v); check("R5 partial clear high", v, pat2[63:32] & ~32'h0000_0300);
    rd(8'hB8, v); check("R5 clear reads zero", v, 32'h0);

    // R9: writes to read-only and unmapped offsets, unmapped reads
    wr(8'hC0, 32'h0);
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hC0, v); check("R9 status write ignored", v, pat2[31:0]);
    rd(8'hA0, v); check("R9 state write ignored", v, 32'h0);
    wr(8'h88, 32'h1234_5678);
    rd(8'h88, v); check("R9 unmapped read", v, 32'h0);
    check("R9 ctrl untouched", ctrlWord, 32'hDEAD_0123);
    rd(8'hB0, v); check("R9 mask untouched", v, 32'hFFFF_FFFF);

    // R6: event and clear on the same bit at the same edge
    clearAll();
    @(negedge clk);
    keyState[0] = 1'b1;
    regAddr = 8'hB8; regWrData = 32'h1; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rd(8'hC0, v); check("R6 event beats clear", v, 32'h1);

    // R7: interrupt follows the mask
    clearAll();
    keyState[40] = 1'b1;
    @(negedge clk);
    wr(8'hB0, 32'h0); wr(8'hB4, 32'h0);
    check("R7 masked off", {31'h0, irqOut}, 32'h0);
    rd(8'hC4, v); check("R7 status latched while masked", v, 32'h0000_0100);
    wr(8'hB4, 32'h0000_0200);
    check("R7 other bit enabled", {31'h0, irqOut}, 32'h0);
    wr(8'hB4, 32'h0000_0100);
    check("R7 own bit enabled", {31'h0, irqOut}, 32'h1);
    wr(8'hBC, 32'h0000_0100);
    check("R7 cleared drops irq", {31'h0, irqOut}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule